// File: doc/BRIEF.md
# Paged 32-bit Register Bridge over 16-bit Management Accesses

This block sits behind a management-bus slave. Each request carries a 5-bit device address, a 5-bit register number and, for writes, 16 bits of data. The block turns these requests into 32-bit accesses on a word-addressed register file.

A 32-bit word address is built from three parts:
- a page register, which holds the upper address bits;
- the low three bits of the device address;
- the upper four bits of the register number.

The lowest bit of the register number picks the half of the word: even for the low half, odd for the high half. Software loads the page first. It then moves a word as two 16-bit transfers.

For a write, the high half goes first and is held back. The backend sees one full 32-bit write only when the low half arrives. For a read, the low half goes first. That access samples the whole word and keeps its upper half, so the later high-half read comes from the same snapshot. Requests to device addresses outside the bridge's window change nothing and read back as all ones.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After reset, no read response is pending, both backend strobes are low, and the page register reads back as zero.
- R2: A write to device 0x1F, register 0x10 loads the page register from bits 8:0 of the write data. A read of that same slot returns the page zero-extended to 16 bits.
- R3: For device addresses 0x10 to 0x17, the backend word address is page * 128 + (device mod 8) * 16 + (register div 2), that is {page, device[2:0], register[4:1]}.
- R4: Bit 0 of the register number selects the half. A value of 0 selects bits 15:0 of the word and a value of 1 selects bits 31:16.
- R5: A high-half write only stages its 16 bits and causes no backend write.
- R6: A low-half write causes exactly one backend write in the same cycle. Its data is {last staged high half, low-half data}.
- R7: A low-half read strobes the backend read in the same cycle. The response carries bits 15:0 of the backend data, and the block captures bits 31:16 at that moment.
- R8: A high-half read does not touch the backend. It returns the upper half captured by the most recent low-half read, even if the backend has changed since.
- R9: Every other request has no effect: no backend strobe and no change to the page register. Reads of such requests return 0xFFFF. This covers any other register of device 0x1F, device addresses 0x00 to 0x0F, and device addresses 0x18 to 0x1E.
- R10: Every read request gets a response flagged valid exactly one cycle later. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_phy | input | 5 | Device address of the request |
| req_reg | input | 5 | Register number of the request |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Read response data |
| be_wr_en | output | 1 | Backend 32-bit write strobe |
| be_rd_en | output | 1 | Backend 32-bit read strobe |
| be_addr | output | 16 | Backend word address |
| be_wdata | output | 32 | Backend write data |
| be_rdata | input | 32 | Backend read data (combinational, same cycle) |

## Verification
The bench checks the snapshot rule. It changes the backend contents between a low-half read and the matching high-half read. A design that re-read the backend, or dropped the captured half, would return the new upper bits.

It writes the high half alone and checks that the backend stays quiet. A design that committed too early would show a spurious backend write. The bench also checks that the low-half commit carries the staged half.

Address-field tests cover the extremes. Page 0x1FF is used together with the highest device and register numbers, and page data is written with stray upper bits set. These cases catch a wrong field order or a truncation error in the address.

Finally, the bench sends requests to the page device's other registers and to devices just outside the window. A decoder that is too wide would load the page or strobe the backend. A decoder with a wrong default would return something other than all ones.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int PHY_W  = 5;
  localparam int REG_W  = 5;
  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PAGE = 2'd1,
    ACC_WORD = 2'd2,
    ACC_MISS = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mrb_decode.sv
module mrb_decode
  import mdio_bridge_pkg::*;
#(
  parameter int              PAGE_W    = 9,
  parameter int              PHY_LO_W  = 3,
  parameter logic [PHY_W-1:0] WIN_BASE = 5'h10,
  parameter logic [PHY_W-1:0] PAGE_PHY = 5'h1F,
  parameter logic [REG_W-1:0] PAGE_REG = 5'h10,
  localparam int             AW        = PAGE_W + PHY_LO_W + REG_W - 1
) (
  input  logic              req_valid,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [PAGE_W-1:0] page,
  output acc_kind_e         kind,
  output logic              half_hi,
  output logic [AW-1:0]     word_addr
);
  localparam logic [PHY_W-1:0] LO_MASK = PHY_W'((1 << PHY_LO_W) - 1);

  function automatic logic in_window(input logic [PHY_W-1:0] phy);
    return (phy & ~LO_MASK) == WIN_BASE;
  endfunction

  function automatic logic [AW-1:0] compose(input logic [PAGE_W-1:0] pg,
                                            input logic [PHY_W-1:0]  phy,
                                            input logic [REG_W-1:0]  rg);
    return {pg, phy[PHY_LO_W-1:0], rg[REG_W-1:1]};
  endfunction

  always_comb begin
    if (!req_valid)
      kind = ACC_NONE;
    else if (req_phy == PAGE_PHY && req_reg == PAGE_REG)
      kind = ACC_PAGE;
    else if (in_window(req_phy))
      kind = ACC_WORD;
    else
      kind = ACC_MISS;
  end

  assign half_hi   = req_reg[0];
  assign word_addr = compose(page, req_phy, req_reg);
endmodule

// File: rtl/mrb_page_reg.sv
module mrb_page_reg #(
  parameter int PAGE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wdata,
  output logic [PAGE_W-1:0] page
);
  always_ff @(posedge clk) begin
    if (!rst_n)     page <= '0;
    else if (wr_en) page <= wdata;
  end

  // R2
  page_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(page) |-> $past(wr_en));

  // R2
  page_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> page == $past(wdata));
endmodule

// File: rtl/mrb_half_asm.sv
module mrb_half_asm
  import mdio_bridge_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              rd_lo,
  input  logic              rd_hi,
  input  logic [AW-1:0]     addr,
  input  logic [HALF_W-1:0] wdata,
  output logic              be_wr_en,
  output logic              be_rd_en,
  output logic [AW-1:0]     be_addr,
  output logic [2*HALF_W-1:0] be_wdata,
  input  logic [2*HALF_W-1:0] be_rdata,
  output logic [HALF_W-1:0] rd_half
);
  logic [HALF_W-1:0] stage_hi;
  logic [HALF_W-1:0] shadow_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_hi  <= '0;
      shadow_hi <= '0;
    end else begin
      if (wr_hi) stage_hi  <= wdata;
      if (rd_lo) shadow_hi <= be_rdata[2*HALF_W-1:HALF_W];
    end
  end

  assign be_wr_en = wr_lo;
  assign be_rd_en = rd_lo;
  assign be_addr  = addr;
  assign be_wdata = {stage_hi, wdata};
  assign rd_half  = rd_hi ? shadow_hi : be_rdata[HALF_W-1:0];

  // R4
  strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({be_wr_en, be_rd_en}));

  // R6
  stage_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi |=> $stable(stage_hi));

  // R8
  shadow_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> $stable(shadow_hi));
endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W   = 9,
  parameter int PHY_LO_W = 3,
  localparam int AW      = PAGE_W + PHY_LO_W + REG_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [HALF_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [HALF_W-1:0] rsp_rdata,
  output logic              be_wr_en,
  output logic              be_rd_en,
  output logic [AW-1:0]     be_addr,
  output logic [2*HALF_W-1:0] be_wdata,
  input  logic [2*HALF_W-1:0] be_rdata
);
  acc_kind_e         kind;
  logic              half_hi;
  logic [AW-1:0]     word_addr;
  logic [PAGE_W-1:0] page;
  logic [HALF_W-1:0] rd_half;
  logic              page_wr, is_word, is_read;
  logic              wr_lo, wr_hi, rd_lo, rd_hi;

  mrb_decode #(.PAGE_W(PAGE_W), .PHY_LO_W(PHY_LO_W)) i_decode (
    .req_valid (req_valid),
    .req_phy   (req_phy),
    .req_reg   (req_reg),
    .page      (page),
    .kind      (kind),
    .half_hi   (half_hi),
    .word_addr (word_addr)
  );

  assign is_read = req_valid && !req_write;
  assign is_word = kind == ACC_WORD;
  assign page_wr = req_valid && req_write && kind == ACC_PAGE;
  assign wr_lo   = req_valid && req_write && is_word && !half_hi;
  assign wr_hi   = req_valid && req_write && is_word &&  half_hi;
  assign rd_lo   = is_read && is_word && !half_hi;
  assign rd_hi   = is_read && is_word &&  half_hi;

  mrb_page_reg #(.PAGE_W(PAGE_W)) i_page (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (page_wr),
    .wdata (req_wdata[PAGE_W-1:0]),
    .page  (page)
  );

  mrb_half_asm #(.AW(AW)) i_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .rd_lo    (rd_lo),
    .rd_hi    (rd_hi),
    .addr     (word_addr),
    .wdata    (req_wdata),
    .be_wr_en (be_wr_en),
    .be_rd_en (be_rd_en),
    .be_addr  (be_addr),
    .be_wdata (be_wdata),
    .be_rdata (be_rdata),
    .rd_half  (rd_half)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= is_read;
      if (is_read) begin
        case (kind)
          ACC_PAGE: rsp_rdata <= HALF_W'(page);
          ACC_WORD: rsp_rdata <= rd_half;
          default:  rsp_rdata <= '1;
        endcase
      end
    end
  end

  // R10
  rsp_only_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R9
  miss_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && kind == ACC_MISS) |=> rsp_rdata == 16'hFFFF);

  // R9
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind == ACC_MISS |-> !be_wr_en && !be_rd_en);

  // R8
  hi_no_backend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_word && half_hi) |-> !be_rd_en && !be_wr_en);

  // R5
  hi_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |-> !be_wr_en);
endmodule

// File: tb/test_mdio_reg_bridge.sv
module test_mdio_reg_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid, be_wr_en, be_rd_en;
  logic [15:0] rsp_rdata, be_addr;
  logic [31:0] be_wdata, be_rdata;
  logic [31:0] salt = '0;

  int tests = 0, fails = 0;
  logic done = 1'b0;

  // sampled values
  logic        s_wr, s_rd, s_rv;
  logic [15:0] s_addr, s_rsp;
  logic [31:0] s_wdata;

  always #5 clk = ~clk;

  assign be_rdata = {be_addr ^ 16'h5A5A, be_addr} ^ salt;

  mdio_reg_bridge i_mdio_reg_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .be_wr_en(be_wr_en),
    .be_rd_en(be_rd_en), .be_addr(be_addr), .be_wdata(be_wdata),
    .be_rdata(be_rdata)
  );

  function automatic logic [15:0] exp_addr(input int pg, input int phy, input int rg);
    return 16'((pg * 128) + ((phy % 8) * 16) + (rg / 2));
  endfunction

  function automatic logic [31:0] backend_word(input logic [15:0] a, input logic [31:0] s);
    return {a ^ 16'h5A5A, a} ^ s;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [15:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd;
    #1;
    s_wr = be_wr_en; s_rd = be_rd_en; s_addr = be_addr; s_wdata = be_wdata;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    #1;
    s_rv = rsp_valid; s_rsp = rsp_rdata;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    check(!be_wr_en && !be_rd_en, "R1 strobes", {be_wr_en, be_rd_en}, 0);
    access(1'b0, 5'h1F, 5'h10, 16'h0);
    check(s_rv && s_rsp == 16'h0000, "R1 page reset", 32'(s_rsp), 0);
  endtask

  task automatic t_page();
    access(1'b1, 5'h1F, 5'h10, 16'hFFAB);
    check(!s_rv, "R10 no rsp on write", 32'(s_rv), 0);
    access(1'b0, 5'h1F, 5'h10, 16'h0);
    check(s_rv && s_rsp == 16'h01AB, "R2 page readback", 32'(s_rsp), 32'h01AB);
  endtask

  task automatic t_write();
    access(1'b1, 5'h15, 5'h0B, 16'hBEEF);
    check(!s_wr && !s_rd, "R5 hi write staged only", {s_wr, s_rd}, 0);
    access(1'b1, 5'h15, 5'h0A, 16'h1234);
    check(s_wr && !s_rd, "R6 lo write commits", {s_wr, s_rd}, 2);
    check(s_addr == exp_addr(9'h1AB, 5'h15, 5'h0A), "R3 write address",
          32'(s_addr), 32'(exp_addr(9'h1AB, 5'h15, 5'h0A)));
    check(s_wdata == 32'hBEEF1234, "R6 write data", s_wdata, 32'hBEEF1234);
  endtask

  task automatic t_read();
    logic [15:0] a;
    logic [31:0] w;
    salt = 32'h0;
    a = exp_addr(9'h1AB, 5'h12, 5'h1C);
    w = backend_word(a, 32'h0);
    access(1'b0, 5'h12, 5'h1C, 16'h0);
    check(s_rd && !s_wr && s_addr == a, "R7 lo read strobe/address", 32'(s_addr), 32'(a));
    check(s_rv && s_rsp == w[15:0], "R7 lo read data", 32'(s_rsp), 32'(w[15:0]));
    salt = 32'hFFFF_0000;
    access(1'b0, 5'h12, 5'h1D, 16'h0);
    check(!s_rd && !s_wr, "R8 hi read no backend", {s_wr, s_rd}, 0);
    check(s_rv && s_rsp == w[31:16], "R8 R4 hi read snapshot", 32'(s_rsp), 32'(w[31:16]));
    salt = 32'h0;
  endtask

  task automatic t_miss();
    access(1'b0, 5'h05, 5'h00, 16'h0);
    check(s_rv && s_rsp == 16'hFFFF && !s_rd, "R9 low phy read", 32'(s_rsp), 32'hFFFF);
    access(1'b0, 5'h18, 5'h02, 16'h0);
    check(s_rv && s_rsp == 16'hFFFF && !s_rd, "R9 phy 0x18 read", 32'(s_rsp), 32'hFFFF);
    access(1'b1, 5'h1E, 5'h00, 16'h5555);
    check(!s_wr, "R9 phy 0x1E write", 32'(s_wr), 0);
    access(1'b1, 5'h1F, 5'h11, 16'h0003);
    check(!s_wr, "R9 page phy other reg write", 32'(s_wr), 0);
    access(1'b0, 5'h1F, 5'h10, 16'h0);
    check(s_rsp == 16'h01AB, "R9 page unchanged", 32'(s_rsp), 32'h01AB);
    access(1'b0, 5'h1F, 5'h11, 16'h0);
    check(s_rsp == 16'hFFFF, "R9 page phy other reg read", 32'(s_rsp), 32'hFFFF);
  endtask

  task automatic t_bounds();
    logic [15:0] a;
    access(1'b1, 5'h1F, 5'h10, 16'h01FF);
    a = exp_addr(9'h1FF, 5'h17, 5'h1E);
    access(1'b0, 5'h17, 5'h1E, 16'h0);
    check(s_rd && s_addr == a && a == 16'hFFFF, "R3 top address", 32'(s_addr), 32'(a));
    access(1'b1, 5'h10, 5'h01, 16'hCAFE);
    access(1'b1, 5'h10, 5'h00, 16'h0001);
    check(s_wr && s_addr == exp_addr(9'h1FF, 5'h10, 5'h00) && s_wdata == 32'hCAFE0001,
          "R3 R6 base of page", s_wdata, 32'hCAFE0001);
    access(1'b1, 5'h11, 5'h02, 16'h0002);
    check(s_wr && s_wdata == 32'hCAFE0002, "R6 stage reused", s_wdata, 32'hCAFE0002);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_page();
    t_write();
    t_read();
    t_miss();
    t_bounds();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule